// File: doc/BRIEF.md
# Glottal Pulse Timing Generator

This block produces the voicing excitation for a formant speech synthesizer that runs at a fixed sample rate of 12 kHz. Once per 5 ms parameter frame it accepts four values: the fundamental frequency in Hz, a linear voicing amplitude, the open quotient in percent and the diplophonia degree in percent. On every sample strobe it advances one sample. It emits a single signed impulse per pitch period and holds a flag that marks the open part of the glottal cycle. Neighbouring noise and filter stages use that flag for pitch-synchronous modulation.

A period is `12000 / F0` samples long, rounded down. The period's parameters come from the frame that is current when the period begins. A shared sequential divider computes them in the interval between two sample strobes. When diplophonia is non-zero, periods pair up. In the first period of each pair the pulse is moved later by a fraction of the closed phase and made weaker. The second period keeps its pulse at sample 0 with full amplitude.

Parameters enter on a valid/ready port. Ready is always high, so the port never applies back-pressure. Every frame presented with valid is taken, and a newer frame replaces one that no period has used yet. The output side is a plain sample-rate register pair that updates on each strobe.

Top module: `glottal_pulse_gen`

## Requirements
- R1: Each period is T0 = floor(12000 / F0) sample strobes long. With diplophonia 0, the pulse falls on sample index 0 of each period, so consecutive pulses are exactly T0 strobes apart.
- R2: With F0 = 0, or with F0 above 12000 so that T0 is 0, the block is idle: `pulse_out` is 0 and `open_phase` is low on every strobe.
- R3: A pulse sample outputs the amplitude as a positive value on the 16-bit signed `pulse_out`. Every other strobe outputs 0. An amplitude of 0 gives no non-zero output.
- R4: `open_phase` is high for sample indices 0 up to floor(T0·OQ/100)−1 of each period and low for the rest. An OQ value above 100 counts as 100.
- R5: With diplophonia DI > 0, the first period of a pair has no pulse at index 0. Its pulse falls at index floor(T0·DI·(100−OQ)/10000), limited to T0−1. The second period has its pulse at index 0. A DI value above 100 counts as 100.
- R6: The delayed pulse of R5 has amplitude floor(AV·(100−DI)/100). The undelayed pulse has amplitude AV.
- R7: A period that starts with DI = 0, or an idle load, resets the pairing. The next period that starts with DI > 0 is the first (delayed) period of a pair. After that, roles alternate period by period.
- R8: Parameters are sampled only at the strobe that outputs the last sample of a period, or at any strobe while idle. They govern the next period. A frame accepted in the same clock as that strobe is the one used.
- R9: Outputs change only at the clock edge that carries a strobe and hold until the next strobe. When leaving idle, the first pulse appears on the strobe after the one that sampled the non-zero F0. Strobes must be at least 4·(DIV_W+2)+3 clocks apart.
- R10: `prm_ready` is high at all times after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | One-clock strobe per output sample |
| prm_valid | input | 1 | Parameter frame present |
| prm_ready | output | 1 | Parameter frame accepted (always high) |
| prm_f0 | input | 16 | Fundamental frequency in Hz |
| prm_av | input | 15 | Linear voicing amplitude |
| prm_oq | input | 7 | Open quotient in percent |
| prm_di | input | 7 | Diplophonia degree in percent |
| pulse_out | output | 16 | Signed impulse sample |
| open_phase | output | 1 | High during the open part of the period |

## Verification
Two events can fall in the same clock: a frame being accepted and the strobe that closes a period and samples the parameters. The bench steps its own sample model up to the last sample of a period. It then drives the new frame and that strobe together, both in directed form and at random points. It judges the result by whether the next period's length, open span and pulse position follow the new frame and not the previous one. Pulse placement and the end of the open span can also land on the same sample index. The random mix of OQ and DI values provokes this, and every strobe is compared against the bench's own model.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int F0_W     = 16;
  localparam int AMP_W    = 15;
  localparam int PCT_W    = 7;
  localparam int PCT_FULL = 100;

  typedef struct packed {
    logic [F0_W-1:0]  f0;
    logic [AMP_W-1:0] av;
    logic [PCT_W-1:0] oq;
    logic [PCT_W-1:0] di;
  } gpt_frame_t;

  typedef enum logic [1:0] {CS_IDLE, CS_START, CS_WAIT, CS_LOAD} calc_state_e;
endpackage

// File: rtl/gpt_divider.sv
module gpt_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    trial, diff;

  always_comb begin
    trial = {rem_q, quo[W-1]};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      rem_q  <= '0;
      den_q  <= den;
      quo    <= num;
      cnt_q  <= CW'(W);
      busy_q <= 1'b1;
      done   <= 1'b0;
    end else if (busy_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_q <= diff[W-1:0];
        quo   <= {quo[W-2:0], 1'b1};
      end else begin
        rem_q <= trial[W-1:0];
        quo   <= {quo[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/gpt_calc.sv
module gpt_calc
  import gpt_pkg::*;
#(
  parameter int SAMPLE_RATE = 12000,
  parameter int DIV_W       = 32,
  parameter int T0_W        = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  gpt_frame_t       snap,
  output logic             ld,
  output logic [T0_W-1:0]  ld_t0,
  output logic [T0_W-1:0]  ld_nopen,
  output logic [T0_W-1:0]  ld_at,
  output logic [AMP_W-1:0] ld_amp
);
  calc_state_e      state;
  logic [1:0]       step;
  logic [F0_W-1:0]  f0_r;
  logic [AMP_W-1:0] av_r;
  logic [PCT_W-1:0] oq_c, di_c;
  logic [T0_W-1:0]  t0_r, nopen_r, dly_r;
  logic [AMP_W-1:0] ampd_r;
  logic             pair_b;

  logic             div_start, div_done;
  logic [DIV_W-1:0] div_num, div_den, div_q;
  logic             first;

  function automatic logic [PCT_W-1:0] sat_pct(input logic [PCT_W-1:0] v);
    return (v > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : v;
  endfunction

  always_comb begin
    div_num = DIV_W'(SAMPLE_RATE);
    div_den = DIV_W'(f0_r);
    unique case (step)
      2'd1: begin
        div_num = DIV_W'(t0_r) * DIV_W'(oq_c);
        div_den = DIV_W'(PCT_FULL);
      end
      2'd2: begin
        div_num = DIV_W'(t0_r) * DIV_W'(di_c) * (DIV_W'(PCT_FULL) - DIV_W'(oq_c));
        div_den = DIV_W'(PCT_FULL * PCT_FULL);
      end
      2'd3: begin
        div_num = DIV_W'(av_r) * (DIV_W'(PCT_FULL) - DIV_W'(di_c));
        div_den = DIV_W'(PCT_FULL);
      end
      default: ;
    endcase
  end

  assign div_start = (state == CS_START);

  gpt_divider #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CS_IDLE;
      step    <= '0;
      f0_r    <= '0;
      av_r    <= '0;
      oq_c    <= '0;
      di_c    <= '0;
      t0_r    <= '0;
      nopen_r <= '0;
      dly_r   <= '0;
      ampd_r  <= '0;
      pair_b  <= 1'b0;
    end else begin
      unique case (state)
        CS_IDLE: if (kick) begin
          f0_r  <= snap.f0;
          av_r  <= snap.av;
          oq_c  <= sat_pct(snap.oq);
          di_c  <= sat_pct(snap.di);
          step  <= '0;
          state <= CS_START;
        end
        CS_START: state <= CS_WAIT;
        CS_WAIT: if (div_done) begin
          unique case (step)
            2'd0: t0_r <= (f0_r == '0 || div_q > DIV_W'(SAMPLE_RATE)) ? '0 : T0_W'(div_q);
            2'd1: nopen_r <= T0_W'(div_q);
            2'd2: dly_r <= T0_W'(div_q);
            default: ampd_r <= AMP_W'(div_q);
          endcase
          if (step == 2'd3) state <= CS_LOAD;
          else begin
            step  <= step + 1'b1;
            state <= CS_START;
          end
        end
        default: begin
          pair_b <= (t0_r == '0 || di_c == '0) ? 1'b0 : ~pair_b;
          state  <= CS_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    first    = (di_c != '0) && !pair_b && (t0_r != '0);
    ld       = (state == CS_LOAD);
    ld_t0    = t0_r;
    ld_nopen = nopen_r;
    ld_at    = '0;
    ld_amp   = av_r;
    if (first) begin
      ld_at  = (dly_r >= t0_r) ? t0_r - 1'b1 : dly_r;
      ld_amp = ampd_r;
    end
  end

  // R9
  no_kick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> state == CS_IDLE);
  // R4
  nopen_le_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> ld_nopen <= ld_t0);
  // R6
  atten_le_av_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> ld_amp <= av_r);
endmodule

// File: rtl/gpt_phase.sv
module gpt_phase
  import gpt_pkg::*;
#(
  parameter int T0_W    = 14,
  parameter int PULSE_W = AMP_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_en,
  input  logic                      ld,
  input  logic [T0_W-1:0]           ld_t0,
  input  logic [T0_W-1:0]           ld_nopen,
  input  logic [T0_W-1:0]           ld_at,
  input  logic [AMP_W-1:0]          ld_amp,
  output logic                      kick,
  output logic signed [PULSE_W-1:0] pulse_out,
  output logic                      open_phase
);
  logic             running;
  logic [T0_W-1:0]  pos, t0, nopen, at;
  logic [AMP_W-1:0] amp;
  logic             last;

  assign last = (pos == t0 - 1'b1);
  assign kick = smp_en && (!running || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      pos        <= '0;
      t0         <= '0;
      nopen      <= '0;
      at         <= '0;
      amp        <= '0;
      pulse_out  <= '0;
      open_phase <= 1'b0;
    end else if (ld) begin
      running <= (ld_t0 != '0);
      pos     <= '0;
      t0      <= ld_t0;
      nopen   <= ld_nopen;
      at      <= ld_at;
      amp     <= ld_amp;
    end else if (smp_en) begin
      pulse_out  <= (running && pos == at) ? $signed({1'b0, amp}) : '0;
      open_phase <= running && (pos < nopen);
      if (running && !last) pos <= pos + 1'b1;
    end
  end

  // R1
  pos_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> pos < t0);
  // R8
  t0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(t0));
  // R9
  ld_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !smp_en);
  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !running && !ld) |=> (pulse_out == '0 && !open_phase));
endmodule

// File: rtl/glottal_pulse_gen.sv
module glottal_pulse_gen
  import gpt_pkg::*;
#(
  parameter int SAMPLE_RATE = 12000,
  parameter int DIV_W       = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    prm_valid,
  output logic                    prm_ready,
  input  logic [F0_W-1:0]         prm_f0,
  input  logic [AMP_W-1:0]        prm_av,
  input  logic [PCT_W-1:0]        prm_oq,
  input  logic [PCT_W-1:0]        prm_di,
  output logic signed [AMP_W:0]   pulse_out,
  output logic                    open_phase
);
  localparam int T0_W = $clog2(SAMPLE_RATE + 1);

  gpt_frame_t       pend, incoming, snap;
  logic             kick, ld;
  logic [T0_W-1:0]  ld_t0, ld_nopen, ld_at;
  logic [AMP_W-1:0] ld_amp;

  assign prm_ready = 1'b1;
  assign incoming  = '{f0: prm_f0, av: prm_av, oq: prm_oq, di: prm_di};
  assign snap      = prm_valid ? incoming : pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend <= '0;
    else if (prm_valid) pend <= incoming;
  end

  gpt_calc #(.SAMPLE_RATE(SAMPLE_RATE), .DIV_W(DIV_W), .T0_W(T0_W)) u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick),
    .snap     (snap),
    .ld       (ld),
    .ld_t0    (ld_t0),
    .ld_nopen (ld_nopen),
    .ld_at    (ld_at),
    .ld_amp   (ld_amp)
  );

  gpt_phase #(.T0_W(T0_W), .PULSE_W(AMP_W + 1)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .ld         (ld),
    .ld_t0      (ld_t0),
    .ld_nopen   (ld_nopen),
    .ld_at      (ld_at),
    .ld_amp     (ld_amp),
    .kick       (kick),
    .pulse_out  (pulse_out),
    .open_phase (open_phase)
  );

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prm_valid |-> prm_ready);
endmodule

// File: tb/sim_glottal_pulse_gen.sv
module sim_glottal_pulse_gen;
  localparam int GAP = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic prm_valid = 1'b0;
  logic prm_ready;
  logic [15:0] prm_f0 = '0;
  logic [14:0] prm_av = '0;
  logic [6:0]  prm_oq = '0;
  logic [6:0]  prm_di = '0;
  logic signed [15:0] pulse_out;
  logic open_phase;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int p_f0 = 0, p_av = 0, p_oq = 0, p_di = 0;
  int m_run = 0, m_pos = 0, m_t0 = 0, m_nopen = 0, m_at = 0, m_amp = 0, m_pairb = 0;

  always #5 clk = ~clk;

  glottal_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
    .prm_valid(prm_valid), .prm_ready(prm_ready),
    .prm_f0(prm_f0), .prm_av(prm_av), .prm_oq(prm_oq), .prm_di(prm_di),
    .pulse_out(pulse_out), .open_phase(open_phase)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference period computation from R1, R4, R5, R6, R7
  task automatic model_load();
    int oqc, dic, dly, ampd;
    bit first;
    oqc = (p_oq > 100) ? 100 : p_oq;
    dic = (p_di > 100) ? 100 : p_di;
    m_t0 = (p_f0 == 0) ? 0 : 12000 / p_f0;
    m_nopen = m_t0 * oqc / 100;
    dly = m_t0 * dic * (100 - oqc) / 10000;
    if (m_t0 > 0 && dly >= m_t0) dly = m_t0 - 1;
    ampd = p_av * (100 - dic) / 100;
    first = (dic != 0) && (m_pairb == 0) && (m_t0 != 0);
    m_at  = first ? dly : 0;
    m_amp = first ? ampd : p_av;
    m_pairb = (m_t0 == 0 || dic == 0) ? 0 : 1 - m_pairb;
    m_run = (m_t0 != 0);
    m_pos = 0;
  endtask

  task automatic drive_frame(input int f0, input int av, input int oq, input int di);
    prm_valid = 1'b1;
    prm_f0 = 16'(f0); prm_av = 15'(av); prm_oq = 7'(oq); prm_di = 7'(di);
    p_f0 = f0; p_av = av; p_oq = oq; p_di = di;
  endtask

  task automatic frame_only(input int f0, input int av, input int oq, input int di);
    @(negedge clk);
    drive_frame(f0, av, oq, di);
    @(negedge clk);
    chk(prm_ready == 1'b1, "R10", int'(prm_ready), 1);
    prm_valid = 1'b0;
  endtask

  task automatic sample(input bit with_frame, input int f0, input int av,
                        input int oq, input int di, input string tag);
    int exp_p, exp_o;
    @(negedge clk);
    smp_en = 1'b1;
    if (with_frame) drive_frame(f0, av, oq, di);
    exp_p = (m_run != 0 && m_pos == m_at) ? m_amp : 0;
    exp_o = (m_run != 0 && m_pos < m_nopen) ? 1 : 0;
    if (m_run == 0 || m_pos == m_t0 - 1) model_load();
    else m_pos++;
    @(negedge clk);
    smp_en = 1'b0;
    prm_valid = 1'b0;
    chk(int'(pulse_out) == exp_p, tag, int'(pulse_out), exp_p);
    chk(int'(open_phase) == exp_o, "R4", int'(open_phase), exp_o);
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) sample(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hold_v;
    void'($urandom(32'd13579));
    repeat (3) @(negedge clk);
    chk(pulse_out == 16'sd0, "R9", int'(pulse_out), 0);
    chk(open_phase == 1'b0, "R9", int'(open_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prm_ready == 1'b1, "R10", int'(prm_ready), 1);

    run(5, "R2");
    // leave idle: first pulse one strobe after the sampling strobe (R9)
    frame_only(400, 1000, 50, 0);
    run(70, "R1");
    // R9: output holds between strobes
    while (!(m_run != 0 && m_pos == m_at)) sample(0, 0, 0, 0, 0, "R1");
    sample(0, 0, 0, 0, 0, "R9");
    hold_v = int'(pulse_out);
    repeat (40) @(negedge clk);
    chk(int'(pulse_out) == hold_v, "R9", int'(pulse_out), hold_v);
    chk(hold_v == 1000, "R9", hold_v, 1000);

    frame_only(400, 0, 30, 0);
    run(40, "R3");
    frame_only(300, 20000, 60, 40);
    run(100, "R6");
    frame_only(300, 9000, 0, 100);
    run(80, "R5");
    frame_only(300, 9000, 20, 0);
    run(50, "R7");
    frame_only(300, 9000, 20, 30);
    run(60, "R7");
    frame_only(250, 7000, 127, 120);
    run(60, "R4");
    frame_only(13000, 7000, 50, 0);
    run(20, "R2");
    frame_only(0, 7000, 50, 0);
    run(10, "R2");

    // R8: frame accepted together with the period-ending strobe
    frame_only(500, 3000, 40, 0);
    run(3, "R8");
    while (!(m_run != 0 && m_pos == m_t0 - 1)) sample(0, 0, 0, 0, 0, "R8");
    sample(1, 200, 4000, 70, 0, "R8");
    run(70, "R8");

    for (int i = 0; i < 430; i++) begin
      bit nf, same;
      int f0, av, oq, di;
      nf = ($urandom % 40) == 0;
      same = (m_run != 0 && m_pos == m_t0 - 1 && ($urandom % 3) == 0);
      f0 = (($urandom % 8) == 0) ? 0 : 150 + int'($urandom % 500);
      av = (($urandom % 8) == 0) ? 0 : int'($urandom % 32768);
      oq = int'($urandom % 128);
      di = (($urandom % 3) == 0) ? 0 : int'($urandom % 128);
      if (nf && !same) frame_only(f0, av, oq, di);
      sample(same, f0, av, oq, di, "R8");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule